// File: doc/BRIEF.md
# Tri-Level Pulse Step Controller

This block converts excursions of a single three-level control line into one-LSB steps of a 7-bit saturating setting. A comparator front end outside the block reduces the line to two flags: one set while the line sits below its low threshold, one set while it sits above its high threshold. With neither flag set the line is at rest (mid level). Pulling the line low and letting it return to mid raises the setting by one. Driving it high and letting it return lowers the setting by one.

Each excursion is timed in clock cycles after a two-stage synchroniser. Excursions shorter than `REJECT_CYC` cycles are treated as glitches. The first qualifying excursion after reset is discarded, because the front end may wake up in an arbitrary state. A count-enable input decides whether a qualifying excursion may move the setting. The step takes effect when the line returns to mid, and a one-cycle strobe marks each actual change.

The control state machine has four states:
- `ST_REST`: the line is at mid.
- `ST_MEAS_LO` / `ST_MEAS_HI`: timing a low or high excursion.
- `ST_DRAIN`: an invalid excursion was seen; the machine waits for mid.

Transitions:
- rest→meas_lo on a low level, and rest→meas_hi on a high level.
- meas→rest on return to mid. The step is decided on this transition.
- rest→drain when both flags are set.
- meas→drain when both flags are set, or when the line swaps directly between low and high.
- drain→rest on mid.

Top module: `tri_step_ctrl`

## Requirements
- R1: After reset the setting equals `INIT_SETTING` (default 64) and the step strobe is low.
- R2: A low excursion (`lo_flag_i`=1, `hi_flag_i`=0) that qualifies, while enabled and after the first excursion, raises the setting by exactly one. The step strobe is high for exactly one cycle, on the same cycle as the new setting.
- R3: A high excursion (`hi_flag_i`=1, `lo_flag_i`=0) that qualifies, while enabled and after the first excursion, lowers the setting by exactly one, with the same one-cycle strobe.
- R4: An excursion held for fewer than `REJECT_CYC` cycles (default 20) never steps. One held for `REJECT_CYC` cycles or more qualifies.
- R5: An excursion yields at most one step however long it lasts, including widths beyond `ACCEPT_CYC` (default 200).
- R6: The first qualifying excursion after reset is discarded without a step, whatever the enable input is at that time.
- R7: With `cnt_en_i` low at the moment the line returns to mid, the setting and the strobe do not change.
- R8: An increment request at 127 leaves the setting at 127 and raises no strobe.
- R9: A decrement request at 0 leaves the setting at 0 and raises no strobe.
- R10: Both flags set together is invalid. Such an excursion, and any excursion that meets it or swaps directly between low and high, produces no step until the line has rested at mid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Count enable; high allows stepping |
| lo_flag_i | input | 1 | Line below low threshold |
| hi_flag_i | input | 1 | Line above high threshold |
| setting_o | output | 7 | Current setting |
| step_o | output | 1 | One-cycle strobe on each change of the setting |

## Verification
A flag change is seen by the state machine two rising edges after it is driven, because of the synchroniser. Any new setting and its strobe appear at the third rising edge after the line is released to mid. An input held for N cycles therefore measures as exactly N cycles. The bench drives on falling edges and pushes each expected setting when it releases the line. The monitor compares the strobe and the setting on falling edges, and a settle check six cycles after every excursion confirms that rejected and suppressed excursions left the setting unchanged.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    // Encoded as {hi, lo}
    typedef enum logic [1:0] {
        LV_MID  = 2'b00,
        LV_LOW  = 2'b01,
        LV_HIGH = 2'b10,
        LV_BAD  = 2'b11
    } level_e;

    typedef enum logic [1:0] {
        ST_REST,
        ST_MEAS_LO,
        ST_MEAS_HI,
        ST_DRAIN
    } state_e;
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tsc_width_ctr.sv
module tsc_width_ctr #(
    parameter int REJECT_CYC = 20,
    parameter int ACCEPT_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic hold_i,
    output logic qual_o
);
    localparam int CW = $clog2(ACCEPT_CYC + 1);
    localparam logic [CW-1:0] CAP = CW'(ACCEPT_CYC);
    localparam logic [CW-1:0] REJ = CW'(REJECT_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (start_i)              cnt_q <= CW'(1);
        else if (hold_i && cnt_q < CAP) cnt_q <= cnt_q + 1'b1;
    end

    assign qual_o = (cnt_q >= REJ);
endmodule

// File: rtl/tsc_step_fsm.sv
module tsc_step_fsm
    import tsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  level_e lvl_i,
    input  logic   cnt_en_i,
    input  logic   qual_i,
    output logic   ctr_start_o,
    output logic   ctr_hold_o,
    output logic   req_up_o,
    output logic   req_dn_o
);
    state_e state_q, state_d;
    logic   armed_q;
    logic   fire;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_REST;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (fire) armed_q <= 1'b1;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_REST: begin
                if (lvl_i == LV_LOW)       state_d = ST_MEAS_LO;
                else if (lvl_i == LV_HIGH) state_d = ST_MEAS_HI;
                else if (lvl_i == LV_BAD)  state_d = ST_DRAIN;
            end
            ST_MEAS_LO: begin
                if (lvl_i == LV_MID)       state_d = ST_REST;
                else if (lvl_i != LV_LOW)  state_d = ST_DRAIN;
            end
            ST_MEAS_HI: begin
                if (lvl_i == LV_MID)       state_d = ST_REST;
                else if (lvl_i != LV_HIGH) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (lvl_i == LV_MID)       state_d = ST_REST;
            end
            default: state_d = ST_REST;
        endcase
    end

    // Outputs
    always_comb begin
        ctr_start_o = 1'b0;
        ctr_hold_o  = 1'b0;
        fire        = 1'b0;
        req_up_o    = 1'b0;
        req_dn_o    = 1'b0;
        unique case (state_q)
            ST_REST:
                ctr_start_o = (lvl_i == LV_LOW) || (lvl_i == LV_HIGH);
            ST_MEAS_LO: begin
                ctr_hold_o = (lvl_i == LV_LOW);
                fire       = (lvl_i == LV_MID) && qual_i;
                req_up_o   = fire && armed_q && cnt_en_i;
            end
            ST_MEAS_HI: begin
                ctr_hold_o = (lvl_i == LV_HIGH);
                fire       = (lvl_i == LV_MID) && qual_i;
                req_dn_o   = fire && armed_q && cnt_en_i;
            end
            ST_DRAIN: ;
            default: ;
        endcase
    end

    // R4: a request only follows a qualified width
    a_r4_width_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (req_up_o || req_dn_o) |-> qual_i);

    // R10: an invalid level never produces a request
    a_r10_bad_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i == LV_BAD) |-> !(req_up_o || req_dn_o));

    // R2 / R3: never both directions at once
    a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_up_o && req_dn_o));
endmodule

// File: rtl/tsc_sat_reg.sv
module tsc_sat_reg #(
    parameter int W    = 7,
    parameter int INIT = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_up_i,
    input  logic         req_dn_i,
    output logic [W-1:0] setting_o,
    output logic         step_o
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] setting_q;
    logic         step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setting_q <= W'(INIT);
            step_q    <= 1'b0;
        end else begin
            step_q <= 1'b0;
            if (req_up_i && setting_q != MAXV) begin
                setting_q <= setting_q + 1'b1;
                step_q    <= 1'b1;
            end else if (req_dn_i && setting_q != '0) begin
                setting_q <= setting_q - 1'b1;
                step_q    <= 1'b1;
            end
        end
    end

    assign setting_o = setting_q;
    assign step_o    = step_q;

    // R8: no overflow past the top code
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (setting_q == MAXV && !req_dn_i) |=> (setting_q == MAXV));

    // R9: no underflow below zero
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (setting_q == '0 && !req_up_i) |=> (setting_q == '0));

    // R2 / R3: any change is exactly one LSB
    a_r2_single_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (setting_q != $past(setting_q)) |->
            ((setting_q == W'($past(setting_q) + 1'b1)) ||
             (setting_q == W'($past(setting_q) - 1'b1))));
endmodule

// File: rtl/tri_step_ctrl.sv
module tri_step_ctrl
    import tsc_pkg::*;
#(
    parameter int SET_W        = 7,
    parameter int INIT_SETTING = 64,
    parameter int REJECT_CYC   = 20,
    parameter int ACCEPT_CYC   = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en_i,
    input  logic             lo_flag_i,
    input  logic             hi_flag_i,
    output logic [SET_W-1:0] setting_o,
    output logic             step_o
);
    logic [1:0] flags_s;
    level_e     lvl;
    logic       ctr_start, ctr_hold, qual;
    logic       req_up, req_dn;

    tsc_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({hi_flag_i, lo_flag_i}),
        .q_o   (flags_s)
    );

    assign lvl = level_e'(flags_s);

    tsc_width_ctr #(.REJECT_CYC(REJECT_CYC), .ACCEPT_CYC(ACCEPT_CYC)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ctr_start),
        .hold_i  (ctr_hold),
        .qual_o  (qual)
    );

    tsc_step_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_i       (lvl),
        .cnt_en_i    (cnt_en_i),
        .qual_i      (qual),
        .ctr_start_o (ctr_start),
        .ctr_hold_o  (ctr_hold),
        .req_up_o    (req_up),
        .req_dn_o    (req_dn)
    );

    tsc_sat_reg #(.W(SET_W), .INIT(INIT_SETTING)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_up_i  (req_up),
        .req_dn_i  (req_dn),
        .setting_o (setting_o),
        .step_o    (step_o)
    );

    // R7: disabled counting holds the setting
    a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_i |=> $stable(setting_o));

    // R5: the strobe lasts a single cycle
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);

    // R2: the strobe accompanies a real change
    a_r2_strobe_change: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> (setting_o != $past(setting_o)));
endmodule

// File: tb/tri_step_ctrl_tb_top.sv
`timescale 1ns/1ps
module tri_step_ctrl_tb_top;
    localparam int REJ  = 20;
    localparam int ACC  = 200;
    localparam int INIT = 64;

    typedef struct {
        int    val;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       lo_f = 1'b0;
    logic       hi_f = 1'b0;
    logic [6:0] setting;
    logic       step;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t sb_q[$];
    int   model = INIT;
    bit   armed = 1'b0;

    always #4 clk = ~clk;

    tri_step_ctrl #(.SET_W(7), .INIT_SETTING(INIT), .REJECT_CYC(REJ), .ACCEPT_CYC(ACC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en_i  (cnt_en),
        .lo_flag_i (lo_f),
        .hi_flag_i (hi_f),
        .setting_o (setting),
        .step_o    (step)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: pops one expected item per strobe
    always @(negedge clk) begin
        if (rst_n && step) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(int'(setting) == e.val, e.tag, int'(setting), e.val);
            end
        end
    end

    // Raw drive of the line for n cycles, no expectation
    task automatic drive(input bit lo, input bit hi, input int n);
        lo_f = lo;
        hi_f = hi;
        repeat (n) @(negedge clk);
    endtask

    task automatic release_and_settle(input string tag);
        lo_f = 1'b0;
        hi_f = 1'b0;
        repeat (6) @(negedge clk);
        check(int'(setting) == model, tag, int'(setting), model);
    endtask

    // Clean excursion with scoreboard expectation
    task automatic excursion(input bit lo, input int n, input string tag);
        exp_t e;
        drive(lo, !lo, n);
        if (n >= REJ) begin
            if (!armed) begin
                armed = 1'b1;
            end else if (cnt_en) begin
                if (lo && model < 127) begin
                    model++;
                    e.val = model; e.tag = tag; sb_q.push_back(e);
                end else if (!lo && model > 0) begin
                    model--;
                    e.val = model; e.tag = tag; sb_q.push_back(e);
                end
            end
        end
        release_and_settle(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(int'(setting) == INIT, "R1 reset setting", int'(setting), INIT);
        check(step == 1'b0, "R1 reset strobe", int'(step), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cnt_en = 1'b1;

        excursion(1'b1, 30, "R6 first discarded");
        excursion(1'b1, 5, "R4 short glitch");
        excursion(1'b1, REJ - 1, "R4 one below reject");
        excursion(1'b1, REJ, "R4 exact reject width R2");
        excursion(1'b0, 30, "R3 decrement");
        excursion(1'b0, REJ - 1, "R4 high below reject");
        excursion(1'b1, 2 * ACC, "R5 long excursion");

        cnt_en = 1'b0;
        excursion(1'b1, 30, "R7 disabled up");
        excursion(1'b0, 30, "R7 disabled down");
        cnt_en = 1'b1;

        drive(1'b1, 1'b1, 30);
        release_and_settle("R10 both flags");
        drive(1'b1, 1'b0, 25);
        drive(1'b1, 1'b1, 10);
        release_and_settle("R10 low then invalid");
        drive(1'b1, 1'b0, 25);
        drive(1'b0, 1'b1, 25);
        release_and_settle("R10 direct swap");
        excursion(1'b1, 25, "R2 after invalid");

        while (model < 127) excursion(1'b1, 22, "R2 climb");
        excursion(1'b1, 22, "R8 at top");
        excursion(1'b1, 40, "R8 at top again");
        for (int i = 0; i < 130; i++) excursion(1'b0, 22, "R3 descend R9");
        check(int'(setting) == 0, "R9 floor", int'(setting), 0);

        check(sb_q.size() == 0, "R2 pending strobes", sb_q.size(), 0);
        finish_run();
    end
endmodule